// File: doc/BRIEF.md
# Marker-Delimited Manchester Frame Decoder

This block watches a serial bit stream, one bit per cycle in which `bit_valid` is high, and hunts for the delimiter pattern 1,1,1,0,0,0. That pattern cannot occur in valid Manchester data. Once the delimiter is found, the bits that follow are read as pairs. A 1,0 pair decodes to a 0 and a 0,1 pair decodes to a 1. Each decoded bit enters a wide identifier register built from several cascaded words.

Decoding ends at the first pair whose two bits are equal. The six bits that start with that pair are then compared against the delimiter. If they match, the collected identifier is published together with the number of decoded bits, and a one-cycle `id_valid` pulse marks it. The matching delimiter also opens the next frame, so a continuous stream of frames is decoded without gaps. If the six bits do not match, the attempt is dropped and the hunt resumes with the bits that arrive next.

In either case the working register and the bit counter are cleared at the end of every attempt. Frames longer than the register are never published.

Top module: `mdec_frame_decoder`

## Requirements
- R1: In the hunting state the delimiter 1,1,1,0,0,0 (oldest bit first) is recognised at any bit offset. The window advances one valid bit at a time. Finding the opening delimiter produces no report.
- R2: After a delimiter, each bit pair 1,0 decodes to 0 and each pair 0,1 decodes to 1. For a published frame of n decoded bits, the first decoded bit sits at `id_out[n-1]` and the last at `id_out[0]`. All higher bits are zero, and `id_bits` equals n.
- R3: Decoding stops at the first pair of equal bits. The frame is published only if that pair and the four bits after it form 1,1,1,0,0,0. Otherwise nothing is published and hunting resumes.
- R4: The delimiter that closes a frame also opens the next one, so frames sent back to back are each published.
- R5: A frame that decodes more than ID_W bits before its stop pair is never published. `id_bits` never exceeds ID_W.
- R6: `id_valid` is high for exactly one cycle. It rises in the cycle after the clock edge that samples the last delimiter bit.
- R7: `id_out` and `id_bits` change only when `id_valid` is high. After any attempt, published or not, the next frame's identifier holds only its own bits.
- R8: Cycles with `bit_valid` low are ignored whatever `bit_in` carries.
- R9: After reset, `id_out`, `id_bits` and `id_valid` are zero and the block is hunting.
- R10: The identifier is held as NUM_WORDS words of WORD_W bits. The top bit of each word moves into bit 0 of the word above, so frames longer than one word keep all of their bits in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| id_out | output | WORD_W*NUM_WORDS | Last published identifier |
| id_bits | output | $clog2(WORD_W*NUM_WORDS+2) | Decoded bit count of the last published identifier |
| id_valid | output | 1 | One-cycle pulse when a new identifier is published |

## Verification
The bench builds the decoder with WORD_W=4 and NUM_WORDS=3, which gives a 12-bit identifier. With this size, every frame length from zero up to two bits beyond the register, under two data patterns, fits in one sweep. The sweep crosses both word boundaries, the exact-fit length and the overflow lengths that must stay unpublished. Idle cycles with toggling data are mixed into part of the sweep. Separate sequences cover stop pairs whose following bits fail the delimiter match, and a delimiter hidden behind leading junk bits.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    localparam int          MARK_LEN     = 6;
    localparam logic [5:0]  MARK_PATTERN = 6'b111000; // oldest bit in MSB
    localparam int          TAIL_BITS    = 4;         // bits after the stop pair

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FIRST,
        ST_SECOND,
        ST_TAIL
    } dec_state_e;

    typedef struct packed {
        logic shift;   // push one decoded bit
        logic bitv;    // decoded bit value
        logic clear;   // wipe working register
        logic report;  // publish working register
    } dec_ctl_t;

    function automatic logic is_marker(input logic [MARK_LEN-1:0] w);
        return w == MARK_PATTERN;
    endfunction

endpackage

// File: rtl/mdec_window.sv
module mdec_window
    import mdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_valid,
    output logic marker_hit
);
    logic [MARK_LEN-2:0] hist_q;
    logic [MARK_LEN-1:0] window;

    assign window     = {hist_q, bit_in};
    assign marker_hit = bit_valid && is_marker(window);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (bit_valid) begin
            hist_q <= window[MARK_LEN-2:0];
        end
    end
endmodule

// File: rtl/mdec_shifter.sv
module mdec_shifter #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    localparam int ID_W     = WORD_W * NUM_WORDS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            shift_bit,
    input  logic            clear,
    output logic [ID_W-1:0] id_q
);
    logic [WORD_W-1:0]    words [NUM_WORDS];
    logic [NUM_WORDS-1:0] carry_in;

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        if (k == 0) begin : g_low
            assign carry_in[k] = shift_bit;
        end else begin : g_up
            assign carry_in[k] = words[k-1][WORD_W-1];
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                words[k] <= '0;
            end else if (shift_en) begin
                words[k] <= {words[k][WORD_W-2:0], carry_in[k]};
            end
        end

        assign id_q[k*WORD_W +: WORD_W] = words[k];
    end
endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
    import mdec_pkg::*;
#(
    parameter int ID_W  = 96,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             marker_hit,
    output dec_ctl_t         ctl,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(ID_W);
    localparam logic [1:0]       TAIL_END = 2'(TAIL_BITS - 1);

    dec_state_e       state_q, state_d;
    logic             first_q, first_d;
    logic [1:0]       tail_q, tail_d;
    logic [CNT_W-1:0] count_q, count_d;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        first_d = first_q;
        tail_d  = tail_q;
        count_d = count_q;
        if (bit_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (marker_hit) begin
                        state_d = ST_FIRST;
                        count_d = '0;
                    end
                end
                ST_FIRST: begin
                    first_d = bit_in;
                    state_d = ST_SECOND;
                end
                ST_SECOND: begin
                    if (bit_in != first_q) begin
                        ctl.shift = 1'b1;
                        ctl.bitv  = bit_in;
                        if (count_q <= LIMIT) begin
                            count_d = count_q + CNT_W'(1);
                        end
                        state_d = ST_FIRST;
                    end else begin
                        tail_d  = '0;
                        state_d = ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (tail_q == TAIL_END) begin
                        ctl.clear = 1'b1;
                        count_d   = '0;
                        if (marker_hit) begin
                            ctl.report = (count_q <= LIMIT);
                            state_d    = ST_FIRST;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end else begin
                        tail_d = tail_q + 2'd1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            first_q <= 1'b0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            first_q <= first_d;
            tail_q  <= tail_d;
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/mdec_frame_decoder.sv
module mdec_frame_decoder
    import mdec_pkg::*;
#(
    parameter int  WORD_W    = 32,
    parameter int  NUM_WORDS = 3,
    localparam int ID_W      = WORD_W * NUM_WORDS,
    localparam int CNT_W     = $clog2(ID_W + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             bit_valid,
    output logic [ID_W-1:0]  id_out,
    output logic [CNT_W-1:0] id_bits,
    output logic             id_valid
);
    logic             marker_hit;
    dec_ctl_t         ctl;
    logic [CNT_W-1:0] count;
    logic [ID_W-1:0]  work_id;

    mdec_window u_window (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .marker_hit (marker_hit)
    );

    mdec_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .marker_hit (marker_hit),
        .ctl        (ctl),
        .count      (count)
    );

    mdec_shifter #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (ctl.shift),
        .shift_bit (ctl.bitv),
        .clear     (ctl.clear),
        .id_q      (work_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            id_out   <= '0;
            id_bits  <= '0;
            id_valid <= 1'b0;
        end else begin
            id_valid <= ctl.report;
            if (ctl.report) begin
                id_out  <= work_id;
                id_bits <= count;
            end
        end
    end
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
    parameter int ID_W  = 96,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_in,
    input logic             bit_valid,
    input logic [ID_W-1:0]  id_out,
    input logic [CNT_W-1:0] id_bits,
    input logic             id_valid
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> !id_valid);

    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> ($stable(id_out) && $stable(id_bits)));

    a_r5_count_limit: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> (int'(id_bits) <= ID_W));

    a_r8_needs_valid_bit: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> $past(bit_valid));

    a_r3_ends_on_zero: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> !$past(bit_in));

    a_r2_empty_frame: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_bits == '0) |-> (id_out == '0));
endmodule

bind mdec_frame_decoder mdec_checker #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .id_out    (id_out),
    .id_bits   (id_bits),
    .id_valid  (id_valid)
);

// File: tb/sim_mdec_frame_decoder.sv
module sim_mdec_frame_decoder;
    localparam int WORD_W    = 4;
    localparam int NUM_WORDS = 3;
    localparam int ID_W      = WORD_W * NUM_WORDS;
    localparam int CNT_W     = $clog2(ID_W + 2);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_in = 1'b0;
    logic             bit_valid = 1'b0;
    logic [ID_W-1:0]  id_out;
    logic [CNT_W-1:0] id_bits;
    logic             id_valid;

    int checks = 0;
    int errors = 0;
    int rep_cnt = 0;
    int stray = 0;
    int total_rep = 0;
    logic [31:0] rep_id = '0;
    logic [31:0] rep_bits = '0;
    logic [31:0] last_id = '0;
    logic [31:0] last_bits = '0;
    bit gap_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mdec_frame_decoder #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .id_out    (id_out),
        .id_bits   (id_bits),
        .id_valid  (id_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one qualified bit; sample outputs at the following falling edge
    task automatic send_bit(input logic b);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        if (id_valid) begin
            rep_cnt++;
            total_rep++;
            rep_id = 32'(id_out);
            rep_bits = 32'(id_bits);
        end
        if (gap_en) begin
            bit_in = ~b; // R8: ignored because bit_valid is low
            @(negedge clk);
            if (id_valid) stray++;
        end
    endtask

    task automatic send_pairs(input logic [31:0] data, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(~data[i]);
            send_bit(data[i]);
        end
    endtask

    task automatic send_marker();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] data;
        logic [31:0] exp_id;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 id_out", 32'(id_out), 32'd0);
        check("R9 id_bits", 32'(id_bits), 32'd0);
        check("R9 id_valid", 32'(id_valid), 32'd0);

        // R1: delimiter after junk at an arbitrary offset, no report on opener
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_marker();
        check("R1 no report on opener", 32'(rep_cnt), 32'd0);

        // sweep of frame lengths, closing delimiter reopens next frame (R4)
        for (int pat = 0; pat < 2; pat++) begin
            for (int n = 0; n <= ID_W + 2; n++) begin
                gap_en = (n % 3 == 0);
                data = (pat == 0) ? 32'h0000_2A5B : 32'(n * 613 + 91);
                rep_cnt = 0;
                send_pairs(data, n);
                send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
                send_bit(1'b0); send_bit(1'b0);
                check("R6 no early report", 32'(rep_cnt), 32'd0);
                send_bit(1'b0);
                if (n <= ID_W) begin
                    exp_id = (n == 0) ? 32'd0 : (data & ((32'd1 << n) - 32'd1));
                    check("R6 report on last delimiter bit", 32'(rep_cnt), 32'd1);
                    check(n > WORD_W ? "R10 id across words" : "R2 id value", rep_id, exp_id);
                    check("R2 id_bits", rep_bits, 32'(n));
                    last_id = exp_id;
                    last_bits = 32'(n);
                end else begin
                    check("R5 overlong frame not reported", 32'(rep_cnt), 32'd0);
                    check("R7 id_out held", 32'(id_out), last_id);
                    check("R7 id_bits held", 32'(id_bits), last_bits);
                end
                gap_en = 1'b0;
                bit_in = ~bit_in;
                @(negedge clk);
                check("R6 pulse one cycle", 32'(id_valid), 32'd0);
            end
        end
        check("R4 every back-to-back frame reported", 32'(total_rep), 32'(2 * (ID_W + 1)));
        check("R8 no report in idle cycles", 32'(stray), 32'd0);

        // R3: stop pair 0,0 cannot open a delimiter
        rep_cnt = 0;
        send_pairs(32'd5, 3);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        check("R3 mismatched stop 00", 32'(rep_cnt), 32'd0);
        check("R7 held after failed attempt", 32'(id_out), last_id);

        // R3: stop pair 1,1 followed by a wrong tail
        send_marker();
        send_pairs(32'd3, 2);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        check("R3 mismatched tail", 32'(rep_cnt), 32'd0);
        check("R7 bits held after failed attempt", 32'(id_bits), last_bits);

        // R7: no residue from failed attempts
        send_marker();
        send_pairs(32'd6, 3);
        send_marker();
        check("R7 report after failures", 32'(rep_cnt), 32'd1);
        check("R7 no residue id", rep_id, 32'd6);
        check("R7 no residue bits", rep_bits, 32'd3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule